// File: doc/BRIEF.md
# In-Order Pipeline Read-After-Write Interlock

This block is the sequencing and hazard control for a five-stage in-order instruction pipeline. The stages are Fetch, Decode, Register-Read, Execute and Write. Instructions arrive one per cycle through a valid/ready handshake. Each instruction carries a tag, an optional destination register and up to two optional source registers. The block moves each instruction forward one stage per cycle. It holds an instruction in Register-Read for as long as any of its sources is still owed a result by an older instruction that sits in Execute or Write.

There is no operand bypass. A consumer reads its sources in the cycle after its producer has finished Write. While the reader waits, the instructions behind it stay in Decode and Fetch, and the input is refused. Each held cycle sends an empty slot into Execute. The block reports which stages are occupied, whether Register-Read is held, a retire pulse carrying the tag of the instruction in Write, and a free-running cycle count.

Cycles are numbered by `cycle_count`, which reads 0 in the first cycle after reset. An instruction offered with `in_valid` in a cycle where `in_ready` is high enters Fetch in the next cycle.

Top module: `raw_interlock_pipe`

## Requirements
- R1: Stages run in the order Fetch, Decode, Register-Read, Execute, Write, one cycle each when nothing blocks. An instruction accepted in cycle p with no hazard has `retire_valid` high in cycle p+5.
- R2: N independent instructions offered back to back from cycle p retire in consecutive cycles, and the last one retires in cycle p+4+N.
- R3: A source that is enabled and nonzero, and that names the destination of an older instruction, holds its reader in Register-Read. The reader leaves Register-Read only after reading in the cycle following the producer's Write cycle, so it is in Execute in cycle W+2, where W is the producer's Write cycle.
- R4: Write-after-write and write-after-read register overlaps never cause a stall.
- R5: Register 0 never causes a stall. An instruction whose destination enable is 0 (a store) never causes a stall, whatever its destination field holds.
- R6: While Register-Read is held, an occupied Decode stage holds and an occupied Fetch stage holds. `in_ready` is low exactly when Fetch holds. Instructions retire in the order they were accepted.
- R7: `stall` is high in every cycle that Register-Read holds an instruction. Execute is empty (`stage_valid` bit 3 low) in the cycle after each such cycle. The `stage_valid` bits are 0 Fetch, 1 Decode, 2 Register-Read, 3 Execute, 4 Write.
- R8: `retire_valid` is high for exactly one cycle per instruction, in its Write cycle, with `retire_tag` equal to that instruction's tag.
- R9: `cycle_count` is 0 in the first cycle after reset and rises by one every cycle.
- R10: Synchronous active-high `rst` empties every stage, clears all pending registers and zeroes `cycle_count`. A reader that follows a reset never waits on a producer that was in flight before it.
- R11: The six-instruction chain (two loads, a multiply of both, an add of the multiply and the second load, a subtract of multiply and add, a store of the subtract) retires its last instruction 18 cycles after the first is offered, with 8 stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered |
| in_tag | input | TAG_W | Identifier returned at retire |
| in_dst_en | input | 1 | Instruction writes a register |
| in_dst | input | REG_W | Destination register |
| in_srca_en | input | 1 | First source is used |
| in_srca | input | REG_W | First source register |
| in_srcb_en | input | 1 | Second source is used |
| in_srcb | input | REG_W | Second source register |
| in_ready | output | 1 | Fetch can take the offered instruction this cycle |
| stage_valid | output | 5 | Occupancy per stage, bit 0 Fetch to bit 4 Write |
| stall | output | 1 | Register-Read is held by a hazard |
| retire_valid | output | 1 | An instruction is in Write |
| retire_tag | output | TAG_W | Tag of the instruction in Write |
| cycle_count | output | CNT_W | Cycles since reset |

## Verification
The hardest situation to reach is a chain of hazards that fills Decode and Fetch while refused input waits. Random idle gaps must sometimes let the queue drain partly before the next dependent instruction arrives. The stimulus draws sources and destinations from only four registers, so most instructions depend on a recent producer and some also overwrite one. Gaps of zero to two cycles are mixed in. A reset issued while a producer is in flight, followed at once by a reader of that register, covers the clearing of pending registers.

// File: rtl/rawpipe_pkg.sv
package rawpipe_pkg;

    parameter int unsigned REG_W      = 5;
    parameter int unsigned TAG_W      = 8;
    localparam int unsigned NUM_REGS  = 1 << REG_W;
    localparam int unsigned NUM_STAGES = 5;

    localparam int unsigned ST_FETCH  = 0;
    localparam int unsigned ST_DECODE = 1;
    localparam int unsigned ST_READ   = 2;
    localparam int unsigned ST_EXEC   = 3;
    localparam int unsigned ST_WRITE  = 4;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic             dst_en;
        logic [REG_W-1:0] dst;
        logic             srca_en;
        logic [REG_W-1:0] srca;
        logic             srcb_en;
        logic [REG_W-1:0] srcb;
    } uop_t;

    // one-hot of the register written by a slot, empty for r0 or no write
    function automatic logic [NUM_REGS-1:0] write_mask(uop_t u);
        logic [NUM_REGS-1:0] m;
        m = '0;
        if (u.valid && u.dst_en && (u.dst != '0))
            m[u.dst] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/rawpipe_slot.sv
module rawpipe_slot
    import rawpipe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  uop_t d,
    output uop_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (!hold)
            q <= d;
    end

endmodule

// File: rtl/rawpipe_scoreboard.sv
module rawpipe_scoreboard
    import rawpipe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  uop_t                ex_q,
    input  uop_t                ex_d,
    input  uop_t                rd_q,
    output logic                hazard,
    output logic [NUM_REGS-1:0] pending
);

    // After the edge the owed registers are those of the new Write slot
    // (old Execute) and the new Execute slot; same-register overlaps stay set.
    always_ff @(posedge clk) begin
        if (rst)
            pending <= '0;
        else
            pending <= write_mask(ex_q) | write_mask(ex_d);
    end

    always_comb begin
        hazard = rd_q.valid &&
                 ((rd_q.srca_en && pending[rd_q.srca]) ||
                  (rd_q.srcb_en && pending[rd_q.srcb]));
    end

    AST_R0_NEVER_OWED: assert property (@(posedge clk) disable iff (rst)
        !pending[0]); // R5

    AST_EXEC_DST_OWED: assert property (@(posedge clk) disable iff (rst)
        (ex_q.valid && ex_q.dst_en && ex_q.dst != '0) |=> pending[$past(ex_q.dst)]); // R3

endmodule

// File: rtl/rawpipe_cycle_ctr.sv
module rawpipe_cycle_ctr #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else
            count <= count + 1'b1;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count == $past(count) + 1'b1); // R9

endmodule

// File: rtl/raw_interlock_pipe.sv
module raw_interlock_pipe
    import rawpipe_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [TAG_W-1:0]      in_tag,
    input  logic                  in_dst_en,
    input  logic [REG_W-1:0]      in_dst,
    input  logic                  in_srca_en,
    input  logic [REG_W-1:0]      in_srca,
    input  logic                  in_srcb_en,
    input  logic [REG_W-1:0]      in_srcb,
    output logic                  in_ready,
    output logic [NUM_STAGES-1:0] stage_valid,
    output logic                  stall,
    output logic                  retire_valid,
    output logic [TAG_W-1:0]      retire_tag,
    output logic [CNT_W-1:0]      cycle_count
);

    uop_t                st_q [NUM_STAGES];
    uop_t                st_d [NUM_STAGES];
    logic [NUM_STAGES-1:0] hold;
    logic                  hazard;
    logic [NUM_REGS-1:0]   pending;

    // hold chain: Read holds on a hazard, each older-side stage holds
    // when occupied and the stage ahead of it holds
    always_comb begin
        logic chain;
        chain = 1'b0;
        hold  = '0;
        for (int i = NUM_STAGES - 1; i >= 0; i--) begin
            if (i == ST_READ)
                chain = st_q[i].valid & hazard;
            else if (i < ST_READ)
                chain = chain & st_q[i].valid;
            if (i <= ST_READ)
                hold[i] = chain;
        end
    end

    assign in_ready = !hold[ST_FETCH];

    always_comb begin
        st_d[ST_FETCH].valid   = in_valid & in_ready;
        st_d[ST_FETCH].tag     = in_tag;
        st_d[ST_FETCH].dst_en  = in_dst_en;
        st_d[ST_FETCH].dst     = in_dst;
        st_d[ST_FETCH].srca_en = in_srca_en;
        st_d[ST_FETCH].srca    = in_srca;
        st_d[ST_FETCH].srcb_en = in_srcb_en;
        st_d[ST_FETCH].srcb    = in_srcb;
        for (int i = 1; i < NUM_STAGES; i++)
            st_d[i] = hold[i-1] ? uop_t'('0) : st_q[i-1];
    end

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        rawpipe_slot u_slot (
            .clk  (clk),
            .rst  (rst),
            .hold (hold[g]),
            .d    (st_d[g]),
            .q    (st_q[g])
        );
        assign stage_valid[g] = st_q[g].valid;
    end

    rawpipe_scoreboard u_sb (
        .clk     (clk),
        .rst     (rst),
        .ex_q    (st_q[ST_EXEC]),
        .ex_d    (st_d[ST_EXEC]),
        .rd_q    (st_q[ST_READ]),
        .hazard  (hazard),
        .pending (pending)
    );

    rawpipe_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .count (cycle_count)
    );

    assign stall        = hold[ST_READ];
    assign retire_valid = st_q[ST_WRITE].valid;
    assign retire_tag   = st_q[ST_WRITE].tag;

    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stage_valid[ST_EXEC]); // R7

    AST_STALL_KEEPS_READ: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(st_q[ST_READ])); // R3

    AST_REFUSE_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> (stage_valid[ST_FETCH] && stage_valid[ST_DECODE] && stall)); // R6

    AST_EXEC_TO_RETIRE: assert property (@(posedge clk) disable iff (rst)
        stage_valid[ST_EXEC] |=> retire_valid); // R8

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (stage_valid == '0 && cycle_count == '0 && pending == '0)); // R10

endmodule

// File: tb/raw_interlock_pipe_bench.sv
module raw_interlock_pipe_bench;
    import rawpipe_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [TAG_W-1:0] in_tag = '0;
    logic             in_dst_en = 1'b0;
    logic [REG_W-1:0] in_dst = '0;
    logic             in_srca_en = 1'b0;
    logic [REG_W-1:0] in_srca = '0;
    logic             in_srcb_en = 1'b0;
    logic [REG_W-1:0] in_srcb = '0;
    logic             in_ready;
    logic [4:0]       stage_valid;
    logic             stall;
    logic             retire_valid;
    logic [TAG_W-1:0] retire_tag;
    logic [31:0]      cycle_count;

    raw_interlock_pipe u_raw_interlock_pipe (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag),
        .in_dst_en(in_dst_en), .in_dst(in_dst),
        .in_srca_en(in_srca_en), .in_srca(in_srca),
        .in_srcb_en(in_srcb_en), .in_srcb(in_srcb),
        .in_ready(in_ready), .stage_valid(stage_valid), .stall(stall),
        .retire_valid(retire_valid), .retire_tag(retire_tag),
        .cycle_count(cycle_count)
    );

    localparam int HORIZON = 512;

    int n_checks = 0;
    int n_fail   = 0;
    int bcyc     = 0;

    // reference state, rebuilt per scenario
    bit exp_rv  [HORIZON];
    int exp_tag [HORIZON];
    bit exp_st  [HORIZON];
    int last_w  [32];
    int prev_d, prev_r, prev_e, max_w;
    int first_p, last_ret, n_stall_seen;
    logic [15:0] lf = 16'hACE1;

    always @(posedge clk) begin
        if (rst) bcyc <= 0;
        else     bcyc <= bcyc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, bcyc);
        end
    endtask

    // every-cycle comparison against the reference schedule
    always @(negedge clk) begin
        int c;
        c = bcyc;
        if (!rst && c < HORIZON) begin
            chk(retire_valid == exp_rv[c], "R8 retire_valid", int'(retire_valid), int'(exp_rv[c]));
            if (exp_rv[c])
                chk(int'(retire_tag) == exp_tag[c], "R6 retire order/tag", int'(retire_tag), exp_tag[c]);
            chk(stall == exp_st[c], "R7 stall", int'(stall), int'(exp_st[c]));
            if (c > 0 && exp_st[c-1])
                chk(!stage_valid[3], "R7 bubble into Execute", int'(stage_valid[3]), 0);
            chk(int'(cycle_count) == c, "R9 cycle_count", int'(cycle_count), c);
            if (retire_valid) last_ret = c;
            if (stall) n_stall_seen++;
        end
    end

    task automatic start_scn();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < HORIZON; i++) begin
            exp_rv[i] = 1'b0; exp_st[i] = 1'b0; exp_tag[i] = 0;
        end
        for (int i = 0; i < 32; i++) last_w[i] = -100;
        prev_d = 0; prev_r = 0; prev_e = 0; max_w = 0;
        first_p = -1; last_ret = -1; n_stall_seen = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic feed(input int tag, input bit de, input int d,
                        input bit ae, input int a, input bit be, input int b,
                        input int gap);
        int p, f, dd, r, e, w, acc;
        repeat (gap) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1; in_tag = TAG_W'(tag);
        in_dst_en = de; in_dst = REG_W'(d);
        in_srca_en = ae; in_srca = REG_W'(a);
        in_srcb_en = be; in_srcb = REG_W'(b);
        p = bcyc;
        if (first_p < 0) first_p = p;
        f  = (p + 1 > prev_d) ? p + 1 : prev_d;
        dd = (f + 1 > prev_r) ? f + 1 : prev_r;
        r  = (dd + 1 > prev_e) ? dd + 1 : prev_e;
        e  = r + 1;
        if (ae && a != 0 && last_w[a] + 2 > e) e = last_w[a] + 2;
        if (be && b != 0 && last_w[b] + 2 > e) e = last_w[b] + 2;
        w = e + 1;
        if (w < HORIZON) begin
            exp_rv[w] = 1'b1;
            exp_tag[w] = tag;
        end
        for (int c = r; c <= e - 2; c++)
            if (c < HORIZON) exp_st[c] = 1'b1;
        prev_d = dd; prev_r = r; prev_e = e;
        if (w > max_w) max_w = w;
        if (de && d != 0) last_w[d] = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        acc = bcyc;
        chk(acc == f - 1, "R6 input accepted cycle", acc, f - 1);
        @(posedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        while (bcyc <= max_w + 2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R10 reset state
        start_scn();
        #1;
        chk(stage_valid == 5'b0, "R10 stages empty", int'(stage_valid), 0);
        chk(cycle_count == 0, "R10 counter zero", int'(cycle_count), 0);
        chk(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);
        chk(retire_valid == 1'b0, "R10 no retire", int'(retire_valid), 0);

        // R1 single instruction latency
        start_scn();
        feed(1, 1, 3, 0, 0, 0, 0, 0);
        drain();
        chk(last_ret - first_p == 5, "R1 single latency", last_ret - first_p, 5);

        // R2 eight independent back to back
        start_scn();
        for (int k = 0; k < 8; k++) feed(10 + k, 1, 1 + k, 1, 20, 1, 21, 0);
        drain();
        chk(last_ret - first_p == 12, "R2 4+N span", last_ret - first_p, 12);
        chk(n_stall_seen == 0, "R2 no stall", n_stall_seen, 0);

        // R11 / R3 chain: ld r1; ld r2; mul r3=r1,r2; add r4=r3,r2; sub r3=r3,r4; st r3
        start_scn();
        feed(1, 1, 1, 0, 0, 0, 0, 0);
        feed(2, 1, 2, 0, 0, 0, 0, 0);
        feed(3, 1, 3, 1, 1, 1, 2, 0);
        feed(4, 1, 4, 1, 3, 1, 2, 0);
        feed(5, 1, 3, 1, 3, 1, 4, 0);
        feed(6, 0, 0, 1, 3, 0, 0, 0);
        drain();
        chk(last_ret - first_p == 18, "R11 chain span", last_ret - first_p, 18);
        chk(n_stall_seen == 8, "R11 stall cycles", n_stall_seen, 8);

        // R4 write-after-write and write-after-read
        start_scn();
        feed(1, 1, 6, 1, 7, 0, 0, 0);
        feed(2, 1, 7, 0, 0, 0, 0, 0);
        feed(3, 1, 6, 1, 9, 0, 0, 0);
        feed(4, 1, 8, 1, 9, 0, 0, 0);
        drain();
        chk(n_stall_seen == 0, "R4 no stall on WAW/WAR", n_stall_seen, 0);
        chk(last_ret - first_p == 8, "R4 span", last_ret - first_p, 8);

        // R5 register 0 and no-destination writers
        start_scn();
        feed(1, 1, 0, 0, 0, 0, 0, 0);
        feed(2, 1, 5, 1, 0, 1, 0, 0);
        feed(3, 0, 10, 1, 11, 0, 0, 0);
        feed(4, 1, 12, 1, 10, 0, 0, 0);
        drain();
        chk(n_stall_seen == 0, "R5 no stall via r0 or store", n_stall_seen, 0);

        // R3 R6 R7 dense random dependences with gaps
        start_scn();
        for (int k = 0; k < 40; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            feed(k, lf[0] | lf[1], int'(lf[3:2]) + 1, lf[4], int'(lf[6:5]) + 1,
                 lf[7] & lf[8], int'(lf[10:9]) + 1, (lf[12:11] == 2'b11) ? 2 : int'(lf[11] & lf[13]));
        end
        drain();
        chk(n_stall_seen > 0, "R3 random stream stalled", n_stall_seen, 1);

        // R10 reset while a producer of r5 is in flight
        start_scn();
        feed(1, 1, 5, 0, 0, 0, 0, 0);
        feed(2, 1, 6, 0, 0, 0, 0, 0);
        start_scn();
        #1;
        chk(stage_valid == 5'b0, "R10 flush mid-flight", int'(stage_valid), 0);
        chk(cycle_count == 0, "R10 counter cleared", int'(cycle_count), 0);
        feed(3, 1, 7, 1, 5, 1, 6, 0);
        drain();
        chk(n_stall_seen == 0, "R10 owed registers cleared", n_stall_seen, 0);
        chk(last_ret - first_p == 5, "R10 reader latency", last_ret - first_p, 5);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule